// File: doc/BRIEF.md
# In-Order Command Slot Dispatcher

The block accepts commands that a host writes into a fixed array of command slots. The slots can be filled in any order. The block hands the commands to one storage device in the exact order they were posted. Each command carries a kind: non-queued, legacy queued, native queued, programmed I/O or DMA. Before the oldest pending command is offered, the block checks it against the commands already outstanding at the device. If the two cannot run together, the command waits, and every younger command waits behind it.

Posting order is kept in a queue of slot indices whose depth equals the slot count. A slot table records which slots are occupied, which have been handed to the device, and the kind of each command. An outstanding tracker counts the commands in flight and records their family. A three-state controller turns these into a valid/ready offer to the device:
- IDLE: nothing is offered.
- HOLD: the oldest command is blocked by a conflict.
- OFFER: the oldest command is presented.

The transitions are:
- IDLE→OFFER when the queue is non-empty and the head is compatible.
- IDLE→HOLD when the queue is non-empty and the head conflicts.
- HOLD→OFFER once the conflict clears.
- OFFER→IDLE on the handshake.

Queued commands use their slot number as the device tag. When the device reports that a command has finished, the slot is freed and a one-cycle completion bit is pulsed for that slot. The host reads the busy bitmap to find free slots.

Top module: `slot_dispatch`

## Requirements
- R1: After reset the busy bitmap, the completion vector and the clash flag are all zero, and no command is offered.
- R2: A post to a free slot sets that slot's busy bit at the next clock edge. Slots may be posted in any order.
- R3: Commands are offered in posting order, whatever their slot numbers. An offer keeps `disp_valid` high and `disp_slot` unchanged until `disp_ready` is seen.
- R4: Kind codes are 0 non-queued, 1 legacy queued, 2 native queued, 3 PIO and 4 DMA. Codes 5 to 7 are treated as non-queued. Kinds 0, 3 and 4 are offered only when no command is outstanding at the device.
- R5: A queued kind is offered only when nothing is outstanding, or when every outstanding command belongs to the same queued family (legacy or native). Otherwise it waits.
- R6: For a queued kind the offer has `disp_queued`=1 and `disp_tag` equal to the slot number. For other kinds both are 0.
- R7: A completion for a dispatched slot clears its busy bit at the next edge. It also raises that slot's bit in `done_vec` for exactly one cycle.
- R8: A completion naming a slot that has not been dispatched changes no busy bit and pulses nothing.
- R9: A post to an occupied slot raises `post_clash` for one cycle. The post is discarded, so it causes no extra dispatch.
- R10: A held head command blocks all younger commands, even compatible ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_valid | input | 1 | Host posts a command this cycle |
| post_slot | input | $clog2(NSLOT) | Slot receiving the command |
| post_kind | input | 3 | Command kind code |
| disp_valid | output | 1 | A command is offered to the device |
| disp_ready | input | 1 | Device accepts the offered command |
| disp_slot | output | $clog2(NSLOT) | Slot of the offered command |
| disp_kind | output | 3 | Kind of the offered command |
| disp_queued | output | 1 | Offered command is a queued kind |
| disp_tag | output | $clog2(NSLOT) | Queue tag (slot number for queued kinds, else 0) |
| done_valid | input | 1 | Device reports a finished command |
| done_slot | input | $clog2(NSLOT) | Slot of the finished command |
| done_vec | output | NSLOT | One-cycle completion pulse per slot |
| busy_map | output | NSLOT | Occupied-slot bitmap |
| post_clash | output | 1 | Pulse on a post to an occupied slot |

## Verification
The in-RTL assertions check the following on every cycle:
- An offer stays stable until accepted.
- An offered slot is always occupied.
- A non-queued dispatch happens only with nothing in flight.
- Completion pulses are one-hot and free their slot.
- The order queue never overflows and the in-flight count never underflows.

Only the bench scenarios can show the rest:
- End-to-end posting order over scattered slots.
- Holding a mixed-family or non-queued command until the device drains.
- Younger commands waiting behind a held head.
- Discarding of stray completions and clashing posts.

// File: rtl/slot_dispatch_pkg.sv
package slot_dispatch_pkg;

    typedef enum logic [2:0] {
        CK_NONQ = 3'd0,
        CK_LEGQ = 3'd1,
        CK_NATQ = 3'd2,
        CK_PIO  = 3'd3,
        CK_DMA  = 3'd4
    } cmd_kind_t;

    typedef enum logic [1:0] {
        FAM_SINGLE = 2'd0,
        FAM_LEGQ   = 2'd1,
        FAM_NATQ   = 2'd2
    } cmd_fam_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_OFFER = 2'd2
    } disp_state_t;

    function automatic cmd_fam_t kind_family(input logic [2:0] k);
        cmd_fam_t f;
        unique case (k)
            CK_LEGQ: f = FAM_LEGQ;
            CK_NATQ: f = FAM_NATQ;
            default: f = FAM_SINGLE;
        endcase
        return f;
    endfunction

    function automatic logic kind_is_queued(input logic [2:0] k);
        return (k == CK_LEGQ) || (k == CK_NATQ);
    endfunction

endpackage

// File: rtl/order_queue.sv
module order_queue #(
    parameter int NSLOT = 32,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [SW-1:0] push_slot,
    input  logic          pop,
    output logic [SW-1:0] head_slot,
    output logic          empty,
    output logic          full
);
    localparam int CW = $clog2(NSLOT + 1);

    logic [SW-1:0] store_q [NSLOT];
    logic [SW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill_q;

    assign empty     = (fill_q == '0);
    assign full      = (fill_q == CW'(NSLOT));
    assign head_slot = store_q[rd_ptr];

    function automatic logic [SW-1:0] bump(input logic [SW-1:0] p);
        return (p == SW'(NSLOT - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            store_q[wr_ptr] <= push_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill_q <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            fill_q <= fill_q + CW'(push) - CW'(pop);
        end
    end

    // R2: busy bitmap gating must keep the queue from overflowing
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));

    // R3: nothing is popped from an empty queue
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/slot_table.sv
module slot_table #(
    parameter int NSLOT = 32,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_valid,
    input  logic [SW-1:0]    post_slot,
    input  logic [2:0]       post_kind,
    output logic             post_ok,
    input  logic             issue_we,
    input  logic [SW-1:0]    issue_slot,
    input  logic             done_valid,
    input  logic [SW-1:0]    done_slot,
    output logic             done_ok,
    input  logic [SW-1:0]    rd_slot,
    output logic [2:0]       rd_kind,
    output logic [NSLOT-1:0] busy_map,
    output logic [NSLOT-1:0] done_vec,
    output logic             post_clash
);
    logic [NSLOT-1:0] busy_q;
    logic [NSLOT-1:0] issued_q;
    logic [2:0]       kind_q [NSLOT];

    assign post_ok  = post_valid && !busy_q[post_slot];
    assign done_ok  = done_valid && issued_q[done_slot];
    assign rd_kind  = kind_q[rd_slot];
    assign busy_map = busy_q;

    always_ff @(posedge clk) begin
        if (post_ok) begin
            kind_q[post_slot] <= post_kind;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q     <= '0;
            issued_q   <= '0;
            done_vec   <= '0;
            post_clash <= 1'b0;
        end else begin
            done_vec   <= '0;
            post_clash <= post_valid && busy_q[post_slot];
            if (post_ok) begin
                busy_q[post_slot] <= 1'b1;
            end
            if (issue_we) begin
                issued_q[issue_slot] <= 1'b1;
            end
            if (done_ok) begin
                busy_q[done_slot]   <= 1'b0;
                issued_q[done_slot] <= 1'b0;
                done_vec[done_slot] <= 1'b1;
            end
        end
    end

    // R7: at most one completion pulse per cycle
    a_r7_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_vec));

    // R7: a pulsed slot is already free
    a_r7_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vec & busy_map) == '0);

    // R9: a clash pulse only follows a post
    a_r9_clash_from_post: assert property (@(posedge clk) disable iff (!rst_n)
        post_clash |-> $past(post_valid));

    // R3: only occupied slots are dispatched
    a_r3_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
        issue_we |-> busy_q[issue_slot]);

endmodule

// File: rtl/issue_tracker.sv
module issue_tracker
    import slot_dispatch_pkg::*;
#(
    parameter int NSLOT = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] head_kind,
    output logic       compat,
    input  logic       issue_fire,
    input  logic [2:0] issue_kind,
    input  logic       done_hit
);
    localparam int CW = $clog2(NSLOT + 1);

    logic [CW-1:0] inflight_q;
    cmd_fam_t      fam_q;

    always_comb begin
        if (inflight_q == '0) begin
            compat = 1'b1;
        end else begin
            compat = kind_is_queued(head_kind) && (fam_q == kind_family(head_kind));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight_q <= '0;
            fam_q      <= FAM_SINGLE;
        end else begin
            inflight_q <= inflight_q + CW'(issue_fire) - CW'(done_hit);
            if (issue_fire) begin
                fam_q <= kind_family(issue_kind);
            end
        end
    end

    // R7: completions never exceed dispatched commands
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        done_hit |-> (inflight_q != '0));

    // R4: a non-queued dispatch leaves exactly one command in flight
    a_r4_single_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_fire && !kind_is_queued(issue_kind) && !done_hit) |=> (inflight_q == CW'(1)));

endmodule

// File: rtl/slot_dispatch.sv
module slot_dispatch
    import slot_dispatch_pkg::*;
#(
    parameter int NSLOT = 32,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_valid,
    input  logic [SW-1:0]    post_slot,
    input  logic [2:0]       post_kind,
    output logic             disp_valid,
    input  logic             disp_ready,
    output logic [SW-1:0]    disp_slot,
    output logic [2:0]       disp_kind,
    output logic             disp_queued,
    output logic [SW-1:0]    disp_tag,
    input  logic             done_valid,
    input  logic [SW-1:0]    done_slot,
    output logic [NSLOT-1:0] done_vec,
    output logic [NSLOT-1:0] busy_map,
    output logic             post_clash
);
    disp_state_t   state_q, state_d;
    logic          post_ok, done_ok;
    logic          q_empty, q_full;
    logic [SW-1:0] head_slot;
    logic [2:0]    head_kind;
    logic          compat;
    logic          fire;

    assign fire = disp_valid && disp_ready;

    order_queue #(.NSLOT(NSLOT), .SW(SW)) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (post_ok),
        .push_slot (post_slot),
        .pop       (fire),
        .head_slot (head_slot),
        .empty     (q_empty),
        .full      (q_full)
    );

    slot_table #(.NSLOT(NSLOT), .SW(SW)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_valid (post_valid),
        .post_slot  (post_slot),
        .post_kind  (post_kind),
        .post_ok    (post_ok),
        .issue_we   (fire),
        .issue_slot (head_slot),
        .done_valid (done_valid),
        .done_slot  (done_slot),
        .done_ok    (done_ok),
        .rd_slot    (head_slot),
        .rd_kind    (head_kind),
        .busy_map   (busy_map),
        .done_vec   (done_vec),
        .post_clash (post_clash)
    );

    issue_tracker #(.NSLOT(NSLOT)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_kind  (head_kind),
        .compat     (compat),
        .issue_fire (fire),
        .issue_kind (head_kind),
        .done_hit   (done_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!q_empty) begin
                    state_d = compat ? ST_OFFER : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (compat) begin
                    state_d = ST_OFFER;
                end
            end
            ST_OFFER: begin
                if (disp_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        disp_valid  = 1'b0;
        disp_slot   = '0;
        disp_kind   = '0;
        disp_queued = 1'b0;
        disp_tag    = '0;
        unique case (state_q)
            ST_OFFER: begin
                disp_valid  = 1'b1;
                disp_slot   = head_slot;
                disp_kind   = head_kind;
                disp_queued = kind_is_queued(head_kind);
                disp_tag    = kind_is_queued(head_kind) ? head_slot : '0;
            end
            default: ;
        endcase
    end

    // R3: an unaccepted offer stays up and unchanged
    a_r3_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_slot)));

    // R3: the offered slot is marked busy
    a_r3_offer_busy: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> busy_map[disp_slot]);

    // R6: a non-queued offer carries no tag
    a_r6_untagged: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_queued) |-> (disp_tag == '0));

    // R3: the controller never offers from an empty queue
    a_r3_offer_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> !q_empty);

endmodule

// File: tb/tb_slot_dispatch.sv
module tb_slot_dispatch;
    localparam int NSLOT = 32;
    localparam int SW    = $clog2(NSLOT);
    localparam time TCLK = 10ns;
    localparam int NVEC  = 6;

    // each entry: {slot[7:3], kind[2:0]}
    localparam logic [7:0] VEC [NVEC] = '{
        {5'd9,  3'd3}, {5'd2, 3'd2}, {5'd30, 3'd4},
        {5'd0,  3'd1}, {5'd17, 3'd0}, {5'd31, 3'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             post_valid = 1'b0;
    logic [SW-1:0]    post_slot = '0;
    logic [2:0]       post_kind = '0;
    logic             disp_valid;
    logic             disp_ready = 1'b0;
    logic [SW-1:0]    disp_slot;
    logic [2:0]       disp_kind;
    logic             disp_queued;
    logic [SW-1:0]    disp_tag;
    logic             done_valid = 1'b0;
    logic [SW-1:0]    done_slot = '0;
    logic [NSLOT-1:0] done_vec;
    logic [NSLOT-1:0] busy_map;
    logic             post_clash;

    int nchk = 0;
    int nfail = 0;

    always #(TCLK/2) clk = ~clk;

    slot_dispatch #(.NSLOT(NSLOT)) dut (
        .clk(clk), .rst_n(rst_n),
        .post_valid(post_valid), .post_slot(post_slot), .post_kind(post_kind),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_slot(disp_slot),
        .disp_kind(disp_kind), .disp_queued(disp_queued), .disp_tag(disp_tag),
        .done_valid(done_valid), .done_slot(done_slot),
        .done_vec(done_vec), .busy_map(busy_map), .post_clash(post_clash)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic post(input int slot, input int kind);
        @(negedge clk);
        post_valid = 1'b1;
        post_slot  = SW'(slot);
        post_kind  = 3'(kind);
        @(negedge clk);
        post_valid = 1'b0;
    endtask

    task automatic wait_disp(input int limit, output bit got);
        got = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (disp_valid) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic take();
        disp_ready = 1'b1;
        @(negedge clk);
        disp_ready = 1'b0;
    endtask

    task automatic complete(input int slot);
        @(negedge clk);
        done_valid = 1'b1;
        done_slot  = SW'(slot);
        @(posedge clk);
        #1;
        chk(done_vec == (NSLOT'(1) << slot), "R7", "done pulse", done_vec, NSLOT'(1) << slot);
        chk(busy_map[slot] == 1'b0, "R7", "slot freed", busy_map[slot], 0);
        @(negedge clk);
        done_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(done_vec == '0, "R7", "pulse one cycle", done_vec, 0);
    endtask

    task automatic idle_no_offer(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (disp_valid) seen = 1'b1;
        end
        chk(!seen, req, "held, no offer", seen, 0);
    endtask

    task automatic expect_offer(input int slot, input int kind, input string req);
        bit got;
        bit q;
        wait_disp(8, got);
        q = (kind == 1) || (kind == 2);
        chk(got, req, "offer appears", got, 1);
        chk(disp_slot == SW'(slot), req, "offered slot", disp_slot, slot);
        chk(disp_queued == q, "R6", "queued flag", disp_queued, q);
        chk(disp_tag == (q ? SW'(slot) : SW'(0)), "R6", "tag", disp_tag, q ? slot : 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nfail++;
        $display("FAIL R3 watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy_map == '0, "R1", "busy map", busy_map, 0);
        chk(done_vec == '0, "R1", "done vec", done_vec, 0);
        chk(disp_valid == 1'b0, "R1", "no offer", disp_valid, 0);
        chk(post_clash == 1'b0, "R1", "clash", post_clash, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: table of posts in scattered slot order, dispatched in posting order
        for (int i = 0; i < NVEC; i++) begin
            post(int'(VEC[i][7:3]), int'(VEC[i][2:0]));
            chk(busy_map[VEC[i][7:3]] == 1'b1, "R2", "busy set", busy_map[VEC[i][7:3]], 1);
        end
        for (int i = 0; i < NVEC; i++) begin
            expect_offer(int'(VEC[i][7:3]), int'(VEC[i][2:0]), "R3");
            take();
            complete(int'(VEC[i][7:3]));
        end
        chk(busy_map == '0, "R7", "all free", busy_map, 0);

        // R5: native queued commands stack
        post(3, 2);
        expect_offer(3, 2, "R5");
        take();
        post(7, 2);
        expect_offer(7, 2, "R5");
        take();
        // R5: legacy queued held behind native queued
        post(1, 1);
        idle_no_offer(5, "R5");
        // R10: a compatible younger command may not overtake
        post(12, 2);
        idle_no_offer(4, "R10");
        // R8: completion for an undispatched slot is ignored
        @(negedge clk);
        done_valid = 1'b1;
        done_slot  = SW'(1);
        @(posedge clk);
        #1;
        chk(done_vec == '0, "R8", "no pulse", done_vec, 0);
        chk(busy_map[1] == 1'b1, "R8", "slot stays busy", busy_map[1], 1);
        @(negedge clk);
        done_valid = 1'b0;
        // R9: post to an occupied slot
        post(7, 3);
        chk(post_clash == 1'b1, "R9", "clash pulse", post_clash, 1);
        @(negedge clk);
        chk(post_clash == 1'b0, "R9", "clash one cycle", post_clash, 0);
        complete(3);
        idle_no_offer(3, "R5");
        complete(7);
        expect_offer(1, 1, "R5");
        take();
        complete(1);
        expect_offer(12, 2, "R10");
        take();
        complete(12);
        idle_no_offer(5, "R9");
        chk(busy_map == '0, "R9", "discarded post left no slot", busy_map, 0);

        // R4: DMA waits for an idle device
        post(4, 2);
        expect_offer(4, 2, "R4");
        take();
        post(20, 4);
        idle_no_offer(4, "R4");
        complete(4);
        expect_offer(20, 4, "R4");
        take();
        // R4: code 6 behaves as non-queued
        post(21, 6);
        idle_no_offer(4, "R4");
        complete(20);
        expect_offer(21, 0, "R4");
        take();
        complete(21);

        // R3: offer held stable without ready
        post(6, 3);
        expect_offer(6, 3, "R3");
        repeat (3) @(negedge clk);
        chk(disp_valid == 1'b1, "R3", "offer held", disp_valid, 1);
        chk(disp_slot == SW'(6), "R3", "slot held", disp_slot, 6);
        take();
        complete(6);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule